// File: doc/BRIEF.md
# Eight-Level Prioritized Interrupt Controller

The block collects up to 32 interrupt lines and drives two active-low request outputs to a processor: a fast request and a normal request. Each line carries a priority level from 0 (most urgent) to 7 (least urgent), an enable bit and a sensing mode. Only a fixed subset of positions is wired to real sources. Lines at other positions are ignored.

Edge-sensing lines are caught in a pending latch. Level-sensing lines follow their input after polarity correction. Every cycle a resolver picks the winning source.

- A source at level 0 can only raise the fast request. The lowest-numbered active, enabled source at that level wins.
- Sources at levels 1 to 7 contend for the normal request. The most urgent level wins, and the lower channel number breaks a tie.
- The winning channel number is shown on the vector output.

When the processor accepts an interrupt, it pulses the acknowledge strobe. This takes the shown channel, clears its edge latch and pushes its level onto a nesting stack. While that level is in service, sources at the same level and at less urgent levels are held off. More urgent sources can still preempt, and a level-0 source can always preempt normal service. An end-of-service strobe pops the stack and restores the previous mask.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Only positions set in the populated mask (default: channels 1 to 18) can request. An input on position 0 or on 19 to 31 never lowers `fiq_no` or `irq_no`.
- R2: Each channel `c` takes its level from `prio_i[3c+2:3c]`. Level 0 is the most urgent and level 7 the least. When levels differ, the most urgent level is the one reported on `vec_o`.
- R3: Among active sources at the same level, the lowest channel number is reported on `vec_o`.
- R4: When an active, enabled source at level 0 is unmasked, `fiq_no` is low and `vec_o` gives the lowest such channel. This takes precedence over any normal request.
- R5: When an active, enabled, unmasked source exists at levels 1 to 7, `irq_no` is low.
- R6: Each channel `c` takes its sensing mode from `mode_i[2c+1:2c]`:
  - 00 is low level.
  - 01 is high level.
  - 10 is a falling edge.
  - 11 is a rising edge.

  An edge event stays pending after the input returns.
- R7: An accepted acknowledge clears the edge-pending latch of the acknowledged channel. Level-sensed sources have no latch: their request drops one cycle after the input goes inactive.
- R8: An accepted acknowledge pushes the acknowledged level. Sources at that level and at less urgent levels are then masked. More urgent levels, including level 0, still request. An acknowledge is accepted only when a winner is shown and its level is unmasked.
- R9: An end-of-service strobe pops the most recent in-service level. The previous mask is restored, and masked sources that are still pending request again.
- R10: `fiq_no` and `irq_no` are registered. After reset they are high and `vec_o` is 0. A level source changes them after one clock edge, and an edge source after two.
- R11: A source whose `enable_i` bit is 0 never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt lines, one per channel |
| enable_i | input | 32 | Per-channel enable |
| mode_i | input | 64 | Two-bit sensing mode per channel |
| prio_i | input | 96 | Three-bit priority level per channel |
| ack_i | input | 1 | Acknowledge strobe; takes the channel on `vec_o` |
| eos_i | input | 1 | End-of-service strobe; pops the nesting stack |
| fiq_no | output | 1 | Fast request, active low, registered |
| irq_no | output | 1 | Normal request, active low, registered |
| vec_o | output | 5 | Winning channel number |

## Verification
A corrupted nesting stack appears at the ports as a request that stays high while a pending source waits. It can also appear as a source that re-requests during its own service, one edge after the end-of-service or acknowledge strobe takes effect. A stuck edge latch keeps a request low after the acknowledge has settled, two edges later. A wrong resolver choice shows on `vec_o` on the first registered edge after the inputs change. Directed scenarios place colliding sources at the same and at different levels, and nest three levels deep, so that each of these faults shows within two cycles.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/prio_irq_sense.sv
module prio_irq_sense
  import prio_irq_pkg::*;
#(
  parameter int unsigned       NUM_CH   = 32,
  parameter logic [NUM_CH-1:0] POP_MASK = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CH-1:0]     src_i,
  input  logic [2*NUM_CH-1:0]   mode_i,
  input  logic [NUM_CH-1:0]     clr_i,
  output logic [NUM_CH-1:0]     pend_o
);
  logic [NUM_CH-1:0] src_q, flag_q, flag_d, raw;

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    sense_e mode;
    logic   rise, fall, is_edge, hit;
    assign mode    = sense_e'(mode_i[2*gc +: 2]);
    assign rise    = src_i[gc] & ~src_q[gc];
    assign fall    = ~src_i[gc] & src_q[gc];
    assign is_edge = (mode == SENSE_FALL) || (mode == SENSE_RISE);
    assign hit     = (mode == SENSE_RISE) ? rise : fall;
    // new event wins over a same-cycle clear
    assign flag_d[gc] = is_edge & (hit | (flag_q[gc] & ~clr_i[gc]));

    always_comb begin
      unique case (mode)
        SENSE_LOW:  raw[gc] = ~src_i[gc];
        SENSE_HIGH: raw[gc] = src_i[gc];
        default:    raw[gc] = flag_q[gc];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      flag_q <= '0;
    end else begin
      src_q  <= src_i;
      flag_q <= flag_d;
    end
  end

  assign pend_o = raw & POP_MASK;
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve #(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned LVL_NUM = 8,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned LVL_W  = $clog2(LVL_NUM)
) (
  input  logic [NUM_CH-1:0]       active_i,
  input  logic [LVL_W*NUM_CH-1:0] prio_i,
  input  logic [LVL_NUM-1:0]      allow_i,
  output logic                    fiq_hit_o,
  output logic [CH_W-1:0]         fiq_ch_o,
  output logic                    irq_hit_o,
  output logic [CH_W-1:0]         irq_ch_o,
  output logic [LVL_W-1:0]        irq_lvl_o
);
  logic [LVL_NUM-1:0] lvl_hit;
  logic [CH_W-1:0]    lvl_ch [LVL_NUM];

  // per level: lowest active channel
  for (genvar gl = 0; gl < LVL_NUM; gl++) begin : g_lvl
    always_comb begin
      lvl_hit[gl] = 1'b0;
      lvl_ch[gl]  = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
        if (active_i[c] && (prio_i[LVL_W*c +: LVL_W] == LVL_W'(gl))) begin
          lvl_hit[gl] = 1'b1;
          lvl_ch[gl]  = CH_W'(c);
        end
      end
    end
  end

  assign fiq_hit_o = lvl_hit[0] & allow_i[0];
  assign fiq_ch_o  = lvl_ch[0];

  always_comb begin
    irq_hit_o = 1'b0;
    irq_ch_o  = '0;
    irq_lvl_o = '0;
    for (int l = LVL_NUM - 1; l >= 1; l--) begin
      if (lvl_hit[l] && allow_i[l]) begin
        irq_hit_o = 1'b1;
        irq_ch_o  = lvl_ch[l];
        irq_lvl_o = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/prio_irq_nest.sv
module prio_irq_nest #(
  parameter int unsigned LVL_NUM = 8,
  parameter int unsigned DEPTH   = 8,
  localparam int unsigned LVL_W  = $clog2(LVL_NUM),
  localparam int unsigned DEP_W  = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [DEP_W-1:0]   depth_o,
  output logic [LVL_W-1:0]   top_o,
  output logic [LVL_NUM-1:0] allow_o
);
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [DEP_W-1:0] depth_q;
  logic             empty, full;
  logic [IDX_W-1:0] top_idx, nxt_idx;

  assign empty   = (depth_q == '0);
  assign full    = (depth_q == DEP_W'(DEPTH));
  assign top_idx = IDX_W'(depth_q - DEP_W'(1));
  assign nxt_idx = IDX_W'(depth_q);
  assign top_o   = empty ? '1 : stk_q[top_idx];
  assign depth_o = depth_q;

  for (genvar gl = 0; gl < LVL_NUM; gl++) begin : g_allow
    assign allow_o[gl] = empty | (LVL_W'(gl) < top_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push_i && pop_i && !empty) begin
      stk_q[top_idx] <= lvl_i;
    end else if (push_i && !full) begin
      stk_q[nxt_idx] <= lvl_i;
      depth_q        <= depth_q + DEP_W'(1);
    end else if (pop_i && !empty) begin
      depth_q <= depth_q - DEP_W'(1);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned       NUM_CH   = 32,
  parameter int unsigned       LVL_NUM  = 8,
  parameter int unsigned       DEPTH    = 8,
  parameter logic [NUM_CH-1:0] POP_MASK = 32'h0007_FFFE,
  localparam int unsigned      CH_W     = $clog2(NUM_CH),
  localparam int unsigned      LVL_W    = $clog2(LVL_NUM),
  localparam int unsigned      DEP_W    = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       src_i,
  input  logic [NUM_CH-1:0]       enable_i,
  input  logic [2*NUM_CH-1:0]     mode_i,
  input  logic [LVL_W*NUM_CH-1:0] prio_i,
  input  logic                    ack_i,
  input  logic                    eos_i,
  output logic                    fiq_no,
  output logic                    irq_no,
  output logic [CH_W-1:0]         vec_o
);
  logic [NUM_CH-1:0]  pend, active, ack_clr;
  logic [LVL_NUM-1:0] allow;
  logic               fiq_hit, irq_hit, ack_ok;
  logic [CH_W-1:0]    fiq_ch, irq_ch, win_ch;
  logic [LVL_W-1:0]   irq_lvl, win_lvl, stk_top;
  logic [DEP_W-1:0]   stk_depth;
  logic               fiq_q, irq_q, vld_q;
  logic [CH_W-1:0]    vec_q;
  logic [LVL_W-1:0]   lvl_q;

  prio_irq_sense #(.NUM_CH(NUM_CH), .POP_MASK(POP_MASK)) u_sense (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .mode_i (mode_i),
    .clr_i  (ack_clr),
    .pend_o (pend)
  );

  assign active = pend & enable_i;

  prio_irq_resolve #(.NUM_CH(NUM_CH), .LVL_NUM(LVL_NUM)) u_resolve (
    .active_i  (active),
    .prio_i    (prio_i),
    .allow_i   (allow),
    .fiq_hit_o (fiq_hit),
    .fiq_ch_o  (fiq_ch),
    .irq_hit_o (irq_hit),
    .irq_ch_o  (irq_ch),
    .irq_lvl_o (irq_lvl)
  );

  // the shown winner may be stale by one cycle: recheck its level
  assign ack_ok  = ack_i & vld_q & allow[lvl_q];
  assign ack_clr = ack_ok ? (NUM_CH'(1) << vec_q) : '0;

  prio_irq_nest #(.LVL_NUM(LVL_NUM), .DEPTH(DEPTH)) u_nest (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ack_ok),
    .pop_i   (eos_i),
    .lvl_i   (lvl_q),
    .depth_o (stk_depth),
    .top_o   (stk_top),
    .allow_o (allow)
  );

  assign win_ch  = fiq_hit ? fiq_ch : irq_ch;
  assign win_lvl = fiq_hit ? '0 : irq_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fiq_q <= 1'b0;
      irq_q <= 1'b0;
      vld_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else begin
      fiq_q <= fiq_hit;
      irq_q <= irq_hit;
      vld_q <= fiq_hit | irq_hit;
      vec_q <= win_ch;
      lvl_q <= win_lvl;
    end
  end

  assign fiq_no = ~fiq_q;
  assign irq_no = ~irq_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned       NUM_CH   = 32,
  parameter int unsigned       LVL_W    = 3,
  parameter int unsigned       DEPTH    = 8,
  parameter int unsigned       DEP_W    = 4,
  parameter int unsigned       CH_W     = 5,
  parameter logic [NUM_CH-1:0] POP_MASK = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             eos_i,
  input logic             fiq_no,
  input logic             irq_no,
  input logic [CH_W-1:0]  vec_o,
  input logic [DEP_W-1:0] depth,
  input logic [LVL_W-1:0] top
);
  AST_ONLY_POPULATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fiq_no || !irq_no) |-> POP_MASK[vec_o]); // R1

  AST_LVL0_SERVICE_MASKS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth != '0 && top == '0) |=> (fiq_no && irq_no)); // R8

  AST_NEST_MORE_URGENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth > $past(depth) && $past(depth) != '0) |-> (top < $past(top))); // R8

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth <= DEP_W'(DEPTH)); // R8

  AST_EOS_POPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && !ack_i && depth != '0) |=> (depth == $past(depth) - DEP_W'(1))); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_CH(NUM_CH), .LVL_W(LVL_W), .DEPTH(DEPTH), .DEP_W(DEP_W),
  .CH_W(CH_W), .POP_MASK(POP_MASK)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ack_i  (ack_i),
  .eos_i  (eos_i),
  .fiq_no (fiq_no),
  .irq_no (irq_no),
  .vec_o  (vec_o),
  .depth  (stk_depth),
  .top    (stk_top)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0, en = '1;
  logic [63:0] mode = {32{2'b01}};
  logic [95:0] prio = {32{3'd7}};
  logic        ack = 1'b0, eos = 1'b0;
  logic        fiq_n, irq_n;
  logic [4:0]  vec;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .enable_i(en), .mode_i(mode),
    .prio_i(prio), .ack_i(ack), .eos_i(eos), .fiq_no(fiq_n), .irq_no(irq_n), .vec_o(vec)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int lvl, input logic [1:0] md);
    prio[3*ch +: 3] = 3'(lvl);
    mode[2*ch +: 2] = md;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    src = '0; en = '1; mode = {32{2'b01}}; prio = {32{3'd7}}; ack = 0; eos = 0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(1); ack = 1'b0; tick(1);
  endtask

  task automatic pulse_eos();
    eos = 1'b1; tick(1); eos = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 reset fiq", fiq_n, 1);
    chk("R10 reset irq", irq_n, 1);
    chk("R10 reset vec", vec, 0);
  endtask

  task automatic t_latency();
    do_reset();
    cfg(5, 3, 2'b01);
    src[5] = 1'b1;
    #1 chk("R10 not yet", irq_n, 1);
    tick(1);
    chk("R10 one edge irq", irq_n, 0);
    chk("R5 irq vec", vec, 5);
    chk("R5 no fiq", fiq_n, 1);
  endtask

  task automatic t_same_level();
    do_reset();
    cfg(9, 2, 2'b01); cfg(4, 2, 2'b01);
    src[9] = 1; src[4] = 1; tick(2);
    chk("R3 lower channel", vec, 4);
    src[4] = 0; tick(2);
    chk("R3 next channel", vec, 9);
  endtask

  task automatic t_levels();
    do_reset();
    cfg(3, 5, 2'b01); cfg(10, 1, 2'b01);
    src[3] = 1; src[10] = 1; tick(2);
    chk("R2 urgent level wins", vec, 10);
  endtask

  task automatic t_fiq();
    do_reset();
    cfg(12, 0, 2'b01); cfg(6, 0, 2'b01); cfg(2, 3, 2'b01);
    src[12] = 1; src[6] = 1; src[2] = 1; tick(2);
    chk("R4 fiq low", fiq_n, 0);
    chk("R4 fiq vec", vec, 6);
    chk("R5 irq also low", irq_n, 0);
  endtask

  task automatic t_unpopulated();
    do_reset();
    cfg(0, 0, 2'b01); cfg(20, 0, 2'b01); cfg(31, 2, 2'b01);
    src[0] = 1; src[20] = 1; src[31] = 1; tick(3);
    chk("R1 fiq quiet", fiq_n, 1);
    chk("R1 irq quiet", irq_n, 1);
  endtask

  task automatic t_enable();
    do_reset();
    cfg(7, 1, 2'b01); en[7] = 0;
    src[7] = 1; tick(2);
    chk("R11 disabled quiet", irq_n, 1);
    en[7] = 1; tick(2);
    chk("R11 enabled irq", irq_n, 0);
    chk("R11 enabled vec", vec, 7);
  endtask

  task automatic t_low_level();
    do_reset();
    cfg(8, 4, 2'b00); tick(2);
    chk("R6 low level req", irq_n, 0);
    chk("R6 low level vec", vec, 8);
    src[8] = 1; tick(1);
    chk("R7 level not latched", irq_n, 1);
  endtask

  task automatic t_rise();
    do_reset();
    cfg(11, 2, 2'b11);
    src[11] = 1; tick(1); src[11] = 0; tick(1);
    chk("R6 rise req", irq_n, 0);
    chk("R6 rise vec", vec, 11);
    tick(3);
    chk("R6 rise held", irq_n, 0);
    pulse_ack();
    chk("R7 ack clears", irq_n, 1);
    pulse_eos(); tick(1);
    chk("R7 latch gone after eos", irq_n, 1);
  endtask

  task automatic t_fall();
    do_reset();
    cfg(13, 6, 2'b10);
    src[13] = 1; tick(2);
    chk("R6 rise ignored in fall mode", irq_n, 1);
    src[13] = 0; tick(2);
    chk("R6 fall req", irq_n, 0);
    chk("R6 fall vec", vec, 13);
  endtask

  task automatic t_nest();
    do_reset();
    cfg(5, 3, 2'b01); cfg(9, 4, 2'b01); cfg(2, 1, 2'b01); cfg(14, 0, 2'b01);
    src[5] = 1; tick(2);
    chk("R8 first req", vec, 5);
    pulse_ack();
    chk("R8 own level masked", irq_n, 1);
    src[9] = 1; tick(2);
    chk("R8 lower level masked", irq_n, 1);
    src[2] = 1; tick(2);
    chk("R8 urgent preempts irq", irq_n, 0);
    chk("R8 urgent vec", vec, 2);
    pulse_ack();
    src[2] = 0; tick(2);
    src[14] = 1; tick(2);
    chk("R8 fiq preempts", fiq_n, 0);
    chk("R8 fiq vec", vec, 14);
    chk("R8 irq masked in nest", irq_n, 1);
    src[14] = 0; tick(2);
    pulse_eos(); tick(1);
    chk("R9 pop keeps level 3 mask", irq_n, 1);
    pulse_eos(); tick(1);
    chk("R9 pop to empty irq", irq_n, 0);
    chk("R9 pop to empty vec", vec, 5);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_same_level();
    t_levels();
    t_fiq();
    t_unpopulated();
    t_enable();
    t_low_level();
    t_rise();
    t_fall();
    t_nest();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule